// File: doc/BRIEF.md
# Skid-Buffered Decode Stage Controller

This block is the decode stage of a superscalar pipeline. It sits between fetch and rename and handles one thread. Each cycle it takes up to `WIDTH` instructions from fetch. When nothing downstream is stalling, it forwards them to rename in the same cycle. Opcode decoding is done elsewhere. This stage owns the flow control and one correctness check: it verifies direct PC-relative branches and redirects fetch when a prediction was wrong.

A later stage can request a stall: rename, execute/writeback or commit. When it does, the stage stops forwarding and pushes arriving instructions into a skid FIFO. It pulses a block indication toward fetch when it enters the blocked state, and an unblock indication when it leaves it. While unblocking, it drains the FIFO oldest first before it accepts fresh fetch input directly.

There are two kinds of squash. A squash from commit takes precedence over everything else. A local squash comes from a mispredicted branch found among the forwarded instructions. Both send the controller through a two-cycle squash sequence, and both discard the FIFO.

The controller has six states, with these encodings on `stage_state`:

| State | Code |
|---|---|
| RUN | 0 |
| IDLE | 1 |
| SQ_START | 2 |
| SQ | 3 |
| BLOCK | 4 |
| UNBLOCK | 5 |

Its transitions are:

- **RUN or IDLE:** on a stall, go to BLOCK. On a mispredict, go to SQ_START. Otherwise go to RUN if any lane was valid, or to IDLE if none was.
- **BLOCK:** go to UNBLOCK when no stall is asserted.
- **UNBLOCK:**
  - On a stall, go back to BLOCK.
  - On a mispredict, go to SQ_START.
  - If the FIFO is empty, go to RUN.
  - Otherwise stay in UNBLOCK.
- **SQ_START:** go to SQ.
- **SQ:** go to RUN.
- **Any state:** a commit squash sends the controller to SQ_START.

Top module: `dec_stage`

## Requirements
- R1: After reset `stage_state` is IDLE (1), no lane is valid toward rename, `fe_block`, `fe_unblock` and `redir_valid` are 0, and `active` is 0.
- R2: In RUN or IDLE with no stall, the valid fetch lanes appear on `rn_valid` and `rn_pc` in the same cycle, lane for lane. The next state is RUN if any lane was valid and IDLE otherwise. Fetch lanes are valid contiguously from lane 0, and lane i occupies bits [i*16 +: 16] of each PC bus.
- R3: Any one of `stall_ren`, `stall_exe` and `stall_cmt` stops forwarding. From RUN, IDLE or UNBLOCK it pulses `fe_block` for one cycle and moves to BLOCK. The fetch input of that cycle, and of every BLOCK cycle, is stored in the skid FIFO.
- R4: In BLOCK with no stall, `fe_unblock` is 1 for that cycle and the next state is UNBLOCK. Nothing is forwarded in BLOCK.
- R5: In UNBLOCK with entries in the FIFO and no stall, up to `WIDTH` entries are forwarded oldest first, while fetch input is appended to the FIFO. UNBLOCK is left for RUN only in a cycle that begins with the FIFO empty; that cycle forwards fetch input directly. The FIFO never holds more than `SKID_DEPTH` entries.
- R6: A forwarded branch (`fe_is_br`=1) mispredicts when it was predicted not taken or when its predicted target differs from its real target. A mispredict drives `redir_valid`=1 with `redir_pc` equal to the real target. The branch itself is forwarded, younger lanes are dropped, the FIFO is flushed, and the next state is SQ_START.
- R7: A forwarded non-branch predicted taken is a control mispredict. It redirects to its own PC plus 4, with the same lane and state effects as R6.
- R8: `cm_squash` moves the stage to SQ_START and empties the FIFO. In that cycle it forwards nothing, raises no redirect and no block or unblock indication, and takes precedence over a local mispredict.
- R9: SQ_START is followed by SQ and then RUN; fetch input in both squash states is dropped.
- R10: `active` is 1 exactly when some lane is forwarded this cycle or the FIFO is not empty.
- R11: At most `WIDTH` lanes go to rename per cycle, and they are always contiguous from lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_valid | input | WIDTH | Valid per fetch lane |
| fe_pc | input | WIDTH*16 | PC per lane |
| fe_is_br | input | WIDTH | Lane holds a direct PC-relative branch |
| fe_tgt | input | WIDTH*16 | Real branch target per lane |
| fe_pred_tk | input | WIDTH | Fetch predicted taken |
| fe_pred_tgt | input | WIDTH*16 | Fetch predicted target |
| stall_ren | input | 1 | Stall request from rename |
| stall_exe | input | 1 | Stall request from execute/writeback |
| stall_cmt | input | 1 | Stall request from commit |
| cm_squash | input | 1 | Squash from commit |
| rn_valid | output | WIDTH | Valid per lane toward rename |
| rn_pc | output | WIDTH*16 | PC per lane toward rename |
| fe_block | output | 1 | Block indication toward fetch |
| fe_unblock | output | 1 | Unblock indication toward fetch |
| redir_valid | output | 1 | Local squash redirect toward fetch |
| redir_pc | output | 16 | Corrected fetch PC |
| active | output | 1 | Stage has work this cycle |
| stage_state | output | 3 | Current controller state |

## Verification
A commit squash and a local branch mispredict can land in the same cycle. The bench provokes this by raising `cm_squash` while a mispredicted branch sits on fetch lane 0. It judges the outcome by `redir_valid` staying 0 and by the next state being SQ_START.

A commit squash can also arrive while the stage is blocked, the FIFO holds entries and the stall has just dropped, so an unblock would otherwise be sent. That case is judged by `fe_unblock` staying 0 and by `active` falling once the FIFO has been discarded.

// File: rtl/dec_pkg.sv
package dec_pkg;
    localparam int PCW        = 16;
    localparam int INST_BYTES = 4;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_IDLE     = 3'd1,
        ST_SQ_START = 3'd2,
        ST_SQ       = 3'd3,
        ST_BLOCK    = 3'd4,
        ST_UNBLOCK  = 3'd5
    } dec_state_t;

    typedef struct packed {
        logic [PCW-1:0] pc;
        logic           is_br;
        logic [PCW-1:0] tgt;
        logic           pred_tk;
        logic [PCW-1:0] pred_tgt;
    } dec_inst_t;
endpackage

// File: rtl/dec_skid.sv
module dec_skid import dec_pkg::*; #(
    parameter int W     = 2,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic [CW-1:0] push_n,
    input  dec_inst_t push_data [W],
    input  logic [CW-1:0] pop_n,
    output dec_inst_t head [W],
    output logic [CW-1:0] count
);
    dec_inst_t     mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_n);
            rd_ptr <= rd_ptr + AW'(pop_n);
            count  <= count + push_n - pop_n;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < W; i++) begin
            if (CW'(i) < push_n && !flush)
                mem[wr_ptr + AW'(i)] <= push_data[i];
        end
    end

    for (genvar g = 0; g < W; g++) begin : g_head
        assign head[g] = mem[rd_ptr + AW'(g)];
    end
endmodule

// File: rtl/dec_brchk.sv
module dec_brchk import dec_pkg::*; #(
    parameter int W = 2
) (
    input  logic [W-1:0]   lane_v,
    input  dec_inst_t      lane [W],
    output logic [W-1:0]   keep,
    output logic           mis,
    output logic [PCW-1:0] fix_pc
);
    logic [W-1:0]   bad;
    logic [PCW-1:0] fix [W];

    for (genvar g = 0; g < W; g++) begin : g_lane
        assign bad[g] = lane[g].is_br
                      ? (!lane[g].pred_tk || lane[g].pred_tgt != lane[g].tgt)
                      : lane[g].pred_tk;
        assign fix[g] = lane[g].is_br ? lane[g].tgt
                                      : lane[g].pc + PCW'(INST_BYTES);
    end

    always_comb begin
        keep   = '0;
        mis    = 1'b0;
        fix_pc = '0;
        for (int i = 0; i < W; i++) begin
            if (!mis) begin
                keep[i] = lane_v[i];
                if (lane_v[i] && bad[i]) begin
                    mis    = 1'b1;
                    fix_pc = fix[i];
                end
            end
        end
    end
endmodule

// File: rtl/dec_stage.sv
module dec_stage import dec_pkg::*; #(
    parameter int WIDTH      = 2,
    parameter int SKID_DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIDTH-1:0]     fe_valid,
    input  logic [WIDTH*PCW-1:0] fe_pc,
    input  logic [WIDTH-1:0]     fe_is_br,
    input  logic [WIDTH*PCW-1:0] fe_tgt,
    input  logic [WIDTH-1:0]     fe_pred_tk,
    input  logic [WIDTH*PCW-1:0] fe_pred_tgt,
    input  logic                 stall_ren,
    input  logic                 stall_exe,
    input  logic                 stall_cmt,
    input  logic                 cm_squash,
    output logic [WIDTH-1:0]     rn_valid,
    output logic [WIDTH*PCW-1:0] rn_pc,
    output logic                 fe_block,
    output logic                 fe_unblock,
    output logic                 redir_valid,
    output logic [PCW-1:0]       redir_pc,
    output logic                 active,
    output logic [2:0]           stage_state
);
    localparam int CW = $clog2(SKID_DEPTH + 1);

    dec_state_t      state_q, state_d;
    dec_inst_t       fe_inst [WIDTH];
    dec_inst_t       skid_head [WIDTH];
    dec_inst_t       grp [WIDTH];
    logic [WIDTH-1:0] grp_v, keep, chk_v;
    logic [CW-1:0]   skid_cnt, push_n, pop_n, fe_cnt;
    logic            stall_any, use_skid, flowing, mis, flush, do_push, flow_state;

    assign stall_any  = stall_ren | stall_exe | stall_cmt;
    assign flow_state = (state_q == ST_RUN) || (state_q == ST_IDLE) || (state_q == ST_UNBLOCK);
    assign use_skid   = (state_q == ST_UNBLOCK) && (skid_cnt != '0);
    assign flowing    = !cm_squash && !stall_any && flow_state;

    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        assign fe_inst[g] = '{pc:       fe_pc[g*PCW +: PCW],
                              is_br:    fe_is_br[g],
                              tgt:      fe_tgt[g*PCW +: PCW],
                              pred_tk:  fe_pred_tk[g],
                              pred_tgt: fe_pred_tgt[g*PCW +: PCW]};
        assign grp[g]   = use_skid ? skid_head[g] : fe_inst[g];
        assign grp_v[g] = use_skid ? (CW'(g) < skid_cnt) : fe_valid[g];
        assign rn_pc[g*PCW +: PCW] = grp[g].pc;
    end

    always_comb begin
        fe_cnt = '0;
        for (int i = 0; i < WIDTH; i++) fe_cnt = fe_cnt + CW'(fe_valid[i]);
    end

    assign chk_v = flowing ? grp_v : '0;

    dec_brchk #(.W(WIDTH)) u_brchk (
        .lane_v (chk_v),
        .lane   (grp),
        .keep   (keep),
        .mis    (mis),
        .fix_pc (redir_pc)
    );

    assign flush   = cm_squash || mis;
    assign do_push = !flush && ((state_q == ST_BLOCK) || (stall_any && flow_state) || use_skid);
    assign push_n  = do_push ? fe_cnt : '0;
    assign pop_n   = (use_skid && flowing && !mis)
                   ? ((skid_cnt >= CW'(WIDTH)) ? CW'(WIDTH) : skid_cnt) : '0;

    dec_skid #(.W(WIDTH), .DEPTH(SKID_DEPTH)) u_skid (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push_n    (push_n),
        .push_data (fe_inst),
        .pop_n     (pop_n),
        .head      (skid_head),
        .count     (skid_cnt)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and handshake outputs
    always_comb begin
        state_d    = state_q;
        fe_block   = 1'b0;
        fe_unblock = 1'b0;
        if (cm_squash) begin
            state_d = ST_SQ_START;
        end else begin
            unique case (state_q)
                ST_RUN, ST_IDLE: begin
                    if (stall_any) begin
                        state_d  = ST_BLOCK;
                        fe_block = 1'b1;
                    end else if (mis) state_d = ST_SQ_START;
                    else              state_d = (|fe_valid) ? ST_RUN : ST_IDLE;
                end
                ST_BLOCK: begin
                    if (!stall_any) begin
                        state_d    = ST_UNBLOCK;
                        fe_unblock = 1'b1;
                    end
                end
                ST_UNBLOCK: begin
                    if (stall_any) begin
                        state_d  = ST_BLOCK;
                        fe_block = 1'b1;
                    end else if (mis)  state_d = ST_SQ_START;
                    else if (!use_skid) state_d = ST_RUN;
                end
                ST_SQ_START: state_d = ST_SQ;
                ST_SQ:       state_d = ST_RUN;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    assign rn_valid    = keep;
    assign redir_valid = mis;
    assign active      = (|keep) || (skid_cnt != '0);
    assign stage_state = state_q;
endmodule

// File: rtl/dec_stage_chk.sv
module dec_stage_chk #(
    parameter int WIDTH = 2,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stall_ren,
    input logic             stall_exe,
    input logic             stall_cmt,
    input logic             cm_squash,
    input logic [WIDTH-1:0] rn_valid,
    input logic             fe_block,
    input logic             fe_unblock,
    input logic             redir_valid,
    input logic             active,
    input logic [2:0]       stage_state,
    input logic [CW-1:0]    skid_cnt
);
    logic stall_any;
    assign stall_any = stall_ren | stall_exe | stall_cmt;

    a_r3_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!cm_squash && stall_any && (stage_state == 3'd0 || stage_state == 3'd1 || stage_state == 3'd5))
        |=> stage_state == 3'd4);

    a_r4_block_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stage_state == 3'd4 |-> rn_valid == '0);

    a_r4_unblock_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_state == 3'd4 && !stall_any && !cm_squash) |-> fe_unblock);

    a_r5_skid_bound: assert property (@(posedge clk) disable iff (!rst_n)
        skid_cnt <= CW'(DEPTH));

    a_r6_redir_squash: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> stage_state == 3'd2);

    a_r8_commit_flush: assert property (@(posedge clk) disable iff (!rst_n)
        cm_squash |=> (stage_state == 3'd2 && skid_cnt == '0));

    a_r8_commit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cm_squash |-> (rn_valid == '0 && !redir_valid && !fe_block && !fe_unblock));

    a_r9_squash_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_state == 3'd2 && !cm_squash) |=> stage_state == 3'd3);

    a_r10_active: assert property (@(posedge clk) disable iff (!rst_n)
        (rn_valid != '0) |-> active);

    a_r11_contig: assert property (@(posedge clk) disable iff (!rst_n)
        (rn_valid & WIDTH'(rn_valid + 1'b1)) == '0);
endmodule

bind dec_stage dec_stage_chk #(.WIDTH(WIDTH), .DEPTH(SKID_DEPTH), .CW($clog2(SKID_DEPTH + 1))) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall_ren   (stall_ren),
    .stall_exe   (stall_exe),
    .stall_cmt   (stall_cmt),
    .cm_squash   (cm_squash),
    .rn_valid    (rn_valid),
    .fe_block    (fe_block),
    .fe_unblock  (fe_unblock),
    .redir_valid (redir_valid),
    .active      (active),
    .stage_state (stage_state),
    .skid_cnt    (skid_cnt)
);

// File: tb/sim_dec_stage.sv
module sim_dec_stage;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  fe_valid, fe_is_br, fe_pred_tk;
    logic [31:0] fe_pc, fe_tgt, fe_pred_tgt;
    logic        stall_ren, stall_exe, stall_cmt, cm_squash;
    logic [1:0]  rn_valid;
    logic [31:0] rn_pc;
    logic        fe_block, fe_unblock, redir_valid, active;
    logic [15:0] redir_pc;
    logic [2:0]  stage_state;
    int          total = 0;
    int          fails = 0;

    always #5 clk = ~clk;

    dec_stage #(.WIDTH(2), .SKID_DEPTH(8)) u0 (.*);

    typedef struct packed {
        logic [1:0]  m;
        logic [15:0] pc;
        logic [1:0]  ev;
        logic [2:0]  es;
    } vec_t;

    localparam vec_t TBL [5] = '{
        '{2'b11, 16'h0100, 2'b11, 3'd0},
        '{2'b01, 16'h0200, 2'b01, 3'd0},
        '{2'b00, 16'h0000, 2'b00, 3'd1},
        '{2'b01, 16'h0280, 2'b01, 3'd0},
        '{2'b11, 16'h0400, 2'b11, 3'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic plain(input logic [1:0] m, input logic [15:0] pc);
        fe_valid = m; fe_pc = {pc + 16'd4, pc};
        fe_is_br = '0; fe_pred_tk = '0; fe_tgt = '0; fe_pred_tgt = '0;
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk); #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; stall_ren = 0; stall_exe = 0; stall_cmt = 0; cm_squash = 0;
        plain(2'b00, 16'h0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R1 state", 32'(stage_state), 32'd1);
        chk("R1 outputs", {rn_valid, fe_block, fe_unblock, redir_valid, active}, 32'd0);

        // R2 table-driven pass-through
        for (int i = 0; i < 5; i++) begin
            plain(TBL[i].m, TBL[i].pc); #1;
            chk("R2 rn_valid", 32'(rn_valid), 32'(TBL[i].ev));
            if (TBL[i].ev[0]) chk("R2 lane0 pc", 32'(rn_pc[15:0]), 32'(TBL[i].pc));
            if (TBL[i].ev[1]) chk("R2 lane1 pc", 32'(rn_pc[31:16]), 32'(TBL[i].pc + 16'd4));
            tick();
            chk("R2 next state", 32'(stage_state), 32'(TBL[i].es));
        end

        // R3 block entry via execute stall
        stall_exe = 1; plain(2'b11, 16'h0500); #1;
        chk("R3 no forward", 32'(rn_valid), 32'd0);
        chk("R3 block pulse", 32'(fe_block), 32'd1);
        tick();
        chk("R3 state", 32'(stage_state), 32'd4);
        plain(2'b01, 16'h0600); #1;
        chk("R3 pulse once", 32'(fe_block), 32'd0);
        chk("R10 active skid", 32'(active), 32'd1);
        tick();
        stall_exe = 0; plain(2'b11, 16'h0700); #1;
        chk("R4 unblock pulse", 32'(fe_unblock), 32'd1);
        chk("R4 no forward", 32'(rn_valid), 32'd0);
        tick();
        chk("R4 state", 32'(stage_state), 32'd5);
        plain(2'b00, 16'h0); #1;
        chk("R5 drain valid", 32'(rn_valid), 32'd3);
        chk("R5 drain order", rn_pc, {16'h0504, 16'h0500});
        tick();
        plain(2'b11, 16'h0800); #1;
        chk("R11 width", 32'(rn_valid), 32'd3);
        chk("R5 skid before fetch", rn_pc, {16'h0700, 16'h0600});
        tick();
        chk("R5 still unblocking", 32'(stage_state), 32'd5);
        plain(2'b00, 16'h0); #1;
        chk("R5 appended order", rn_pc, {16'h0800, 16'h0704});
        tick();
        #1;
        chk("R5 last entry", {rn_valid, rn_pc[15:0]}, {14'd0, 2'b01, 16'h0804});
        tick();
        chk("R5 stays until empty", 32'(stage_state), 32'd5);
        plain(2'b11, 16'h0900); #1;
        chk("R5 direct pass", rn_pc, {16'h0904, 16'h0900});
        tick();
        chk("R5 back to run", 32'(stage_state), 32'd0);
        plain(2'b00, 16'h0); #1;
        chk("R10 inactive", 32'(active), 32'd0);
        tick();

        // R3 other stall sources
        stall_ren = 1; #1;
        chk("R3 rename stall", 32'(fe_block), 32'd1);
        tick();
        stall_ren = 0; tick();
        chk("R4 unblock state", 32'(stage_state), 32'd5);
        stall_cmt = 1; #1;
        chk("R3 commit stall", {fe_block, rn_valid}, 32'b100);
        tick();
        chk("R3 reblock", 32'(stage_state), 32'd4);
        stall_cmt = 0; tick(); tick(); tick();
        chk("R2 idle", 32'(stage_state), 32'd1);

        // R6 branch predicted not taken
        plain(2'b11, 16'h0A00); fe_is_br = 2'b01; fe_tgt[15:0] = 16'h0B00; #1;
        chk("R6 redirect", {redir_valid, redir_pc}, {15'd0, 1'b1, 16'h0B00});
        chk("R6 younger dropped", 32'(rn_valid), 32'd1);
        tick();
        chk("R6 squash start", 32'(stage_state), 32'd2);
        plain(2'b11, 16'h0C00); #1;
        chk("R9 drop start", 32'(rn_valid), 32'd0);
        tick();
        chk("R9 squashing", 32'(stage_state), 32'd3);
        #1;
        chk("R9 drop squashing", 32'(rn_valid), 32'd0);
        tick();
        chk("R9 to run", 32'(stage_state), 32'd0);

        // R6 correct branch prediction
        plain(2'b11, 16'h0D00); fe_is_br = 2'b10; fe_pred_tk = 2'b10;
        fe_tgt[31:16] = 16'h0E00; fe_pred_tgt[31:16] = 16'h0E00; #1;
        chk("R6 correct no redirect", {redir_valid, rn_valid}, 32'b011);
        tick();

        // R7 non-branch predicted taken
        plain(2'b11, 16'h0F00); fe_pred_tk = 2'b01; #1;
        chk("R7 control redirect", {redir_valid, redir_pc}, {15'd0, 1'b1, 16'h0F04});
        chk("R7 lanes", 32'(rn_valid), 32'd1);
        tick(); plain(2'b00, 16'h0); tick(); tick();

        // R6 wrong target
        plain(2'b11, 16'h1000); fe_is_br = 2'b01; fe_pred_tk = 2'b01;
        fe_tgt[15:0] = 16'h1100; fe_pred_tgt[15:0] = 16'h1200; #1;
        chk("R6 wrong target", {redir_valid, redir_pc, rn_valid}, {13'd0, 1'b1, 16'h1100, 2'b01});
        tick(); plain(2'b00, 16'h0); tick(); tick();

        // R8 commit squash while blocked with skid entries
        stall_ren = 1; plain(2'b11, 16'h2000); tick();
        stall_ren = 0; cm_squash = 1; plain(2'b11, 16'h2100); #1;
        chk("R8 quiet", {rn_valid, fe_block, fe_unblock, redir_valid}, 32'd0);
        chk("R10 active held", 32'(active), 32'd1);
        tick();
        cm_squash = 0; plain(2'b00, 16'h0); #1;
        chk("R8 state", 32'(stage_state), 32'd2);
        chk("R8 skid flushed", 32'(active), 32'd0);
        tick(); tick(); tick();

        // R8 commit squash beats a local mispredict
        cm_squash = 1; plain(2'b01, 16'h3000); fe_is_br = 2'b01; fe_tgt[15:0] = 16'h3300; #1;
        chk("R8 priority", {redir_valid, rn_valid}, 32'd0);
        tick();
        chk("R8 priority state", 32'(stage_state), 32'd2);
        cm_squash = 0; plain(2'b00, 16'h0);
        tick(); tick();
        finish_run();
    end
endmodule